// File: doc/BRIEF.md
# Read-After-Read Hazard Spacer

This block sits on the read-request path between a host and a memory-mapped network controller. Some controller registers change their contents only a while after a related resource has been read. Examples are the receive and transmit status queues, the receive data queue and a dropped-frame counter. A host that reads the dependent register too soon gets stale data. The spacer sorts every read request by its address. It remembers when each side-effect read was accepted, and it holds a later read of the matching dependent register until the required interval has passed.

The intervals are given in nanoseconds and converted to clock cycles, rounded up. Each of the three hazard channels has its own timer. Reads that no pending channel guards pass straight through with no added latency. When the dummy-fill mode is on, a blocked read does not sit idle. The spacer issues harmless reads of a test register downstream, and releases the dependent read after enough of them, or earlier if the timer has already run out. Each dummy read is counted as one bus cycle of `BUS_CYCLE_NS`. The downstream port is assumed to take at least that long per access. An output counter reports how many cycles the block has held a request because of a hazard.

Top module: `rd_hazard_spacer`

## Requirements
- R1: After reset no hazard is pending and `stall_cnt` is 0. With `h_valid` low, `h_ready` follows `d_ready` and `d_valid` is 0. The first read after reset is accepted on the first edge where it is presented, including a read of a dependent register.
- R2: A read of an address that no pending channel guards is forwarded in the same cycle, with `d_addr` = `h_addr` and `d_dummy` = 0. Such a read does not clear any pending hazard.
- R3: A read of the receive-info register (0x7C) is held after an accepted read of the receive data queue (0x00) or the receive status queue (0x40). If that side-effect read was accepted at edge k, the info read is accepted no earlier than edge k + ceil(495000/`CLK_PS`). With the defaults this is k + 62.
- R4: A read of the transmit-info register (0x80) is held for the same 495 ns interval after an accepted read of the transmit status queue (0x48). This channel is independent of the receive channel.
- R5: Two reads of the dropped-frame counter (0xA0) are spaced by ceil(660000/`CLK_PS`) edges. With the defaults this is 83.
- R6: Each new side-effect read restarts its channel's interval, measured from the edge where the new read was accepted.
- R7: With `cfg_dummy_mode` = 1, a blocked read causes the block to drive `d_valid` = 1, `d_addr` = test register (0x64), `d_dummy` = 1 and `h_ready` = 0. Once ceil(interval/`BUS_CYCLE_NS`) dummy reads have been accepted, the dependent read is released on the next edge. That is 3 dummy reads for a 495 ns rule and 4 for the 660 ns rule.
- R8: In dummy-fill mode, idle time alone still satisfies a rule. If the interval has elapsed, the dependent read passes without any dummy read.
- R9: `stall_cnt` increments once for each edge on which a request is presented, `d_ready` is high and a hazard blocks it. It never changes otherwise.
- R10: When `d_ready` is low, `h_ready` is 0 and the request waits. This wait is not counted in `stall_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dummy_mode | input | 1 | 1: fill waits with test-register reads |
| h_valid | input | 1 | Host read request valid |
| h_addr | input | ADDR_W | Host read address |
| h_ready | output | 1 | Host request accepted on this edge when high with h_valid |
| d_valid | output | 1 | Downstream read request valid |
| d_addr | output | ADDR_W | Downstream read address |
| d_dummy | output | 1 | Current downstream read is a filler read |
| d_ready | input | 1 | Downstream accepts the request |
| stall_cnt | output | STALL_W | Number of hazard stall cycles so far |

## Verification
Several properties are checked on every cycle by the assertions:
- no guarded read reaches the downstream port while its channel is pending;
- forwarded reads keep their address;
- filler reads appear only in dummy-fill mode, with the host held;
- backpressure always holds the host;
- the stall counter moves only on hazard-blocked cycles.

Only the bench's scenarios can show the exact release edge for each pair of registers, the restart of an interval, the number of filler reads per rule, and that unrelated traffic leaves a pending hazard in place. The bench does this by predicting the acceptance edge of each read and comparing it with the edge the design actually produces.

// File: rtl/rhs_pkg.sv
// Shared definitions for the read hazard spacer.
// Assumes callers pass positive divisors to ceil_div.
package rhs_pkg;

    localparam int NCH     = 3;   // number of hazard channels
    localparam int CH_RX   = 0;   // receive-info guard channel
    localparam int CH_TX   = 1;   // transmit-info guard channel
    localparam int CH_DROP = 2;   // dropped-frame counter channel

    // Integer division rounded up
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/rhs_addr_classifier.sv
// Sorts a read address into hazard roles.
// trig: the channels whose interval restarts when this address is read.
// guard: the channel (at most one) that must be idle before this address may be read.
// Assumes the register addresses are distinct.
module rhs_addr_classifier
    import rhs_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  A_RXDATA   = 8'h00,
    parameter logic [7:0]  A_RXSTAT   = 8'h40,
    parameter logic [7:0]  A_TXSTAT   = 8'h48,
    parameter logic [7:0]  A_RXINFO   = 8'h7C,
    parameter logic [7:0]  A_TXINFO   = 8'h80,
    parameter logic [7:0]  A_DROP     = 8'hA0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    trig,
    output logic [NCH-1:0]    guard
);

    // Decode the side-effect sources and the guarded targets
    always_comb begin
        trig  = '0;
        guard = '0;
        if (addr == ADDR_W'(A_RXDATA) || addr == ADDR_W'(A_RXSTAT)) trig[CH_RX] = 1'b1;
        if (addr == ADDR_W'(A_TXSTAT)) trig[CH_TX] = 1'b1;
        if (addr == ADDR_W'(A_DROP)) begin
            trig[CH_DROP]  = 1'b1;
            guard[CH_DROP] = 1'b1;
        end
        if (addr == ADDR_W'(A_RXINFO)) guard[CH_RX] = 1'b1;
        if (addr == ADDR_W'(A_TXINFO)) guard[CH_TX] = 1'b1;
    end

endmodule

// File: rtl/rhs_hazard_timer.sv
// One hazard channel.
// A load arms the channel. It is then pending until WAIT_CYC edges have passed
// since the load, or until DUMMY_N filler reads have been credited, whichever comes first.
// Assumes WAIT_CYC >= 1 and DUMMY_N >= 1.
module rhs_hazard_timer #(
    parameter int WAIT_CYC = 62,
    parameter int DUMMY_N  = 3,
    localparam int CYC_W   = $clog2(WAIT_CYC + 1),
    localparam int DCNT_W  = $clog2(DUMMY_N + 1),
    localparam int LOAD_CYC = (WAIT_CYC > 0) ? WAIT_CYC - 1 : 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dummy_ack,
    output logic pending
);

    logic [CYC_W-1:0]  tmr;
    logic [DCNT_W-1:0] dcnt;

    // Count down the remaining cycles and filler credits; restart on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr  <= '0;
            dcnt <= '0;
        end else if (load) begin
            tmr  <= CYC_W'(LOAD_CYC);
            dcnt <= DCNT_W'(DUMMY_N);
        end else begin
            if (tmr != '0) tmr <= tmr - 1'b1;
            if (dummy_ack && dcnt != '0) dcnt <= dcnt - 1'b1;
        end
    end

    // Blocked only while both time and filler credit remain
    assign pending = (tmr != '0) && (dcnt != '0);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= CYC_W'(LOAD_CYC)); // R3
    AST_DCNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> dcnt <= $past(dcnt)); // R7
    AST_CLEAR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !load) |=> !pending); // R6

endmodule

// File: rtl/rhs_stall_counter.sv
// Counts the cycles on which a presented request was held by a hazard.
// The count wraps modulo 2**STALL_W.
module rhs_stall_counter #(
    parameter int STALL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    output logic [STALL_W-1:0] count
);

    // Advance once for each hazard stall cycle
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (hit) count <= count + 1'b1;
    end

endmodule

// File: rtl/rd_hazard_spacer.sv
// Read-after-read hazard spacer.
// Forwards host read requests downstream and holds a read of a dependent register
// until its channel's interval has passed since the last side-effect read.
// In dummy-fill mode it fills the wait with test-register reads.
// Assumes the host keeps h_addr stable while h_valid is high and h_ready is low.
module rd_hazard_spacer
    import rhs_pkg::*;
#(
    parameter int         ADDR_W       = 8,
    parameter int         STALL_W      = 16,
    parameter int         CLK_PS       = 8000,
    parameter int         BUS_CYCLE_NS = 165,
    parameter int         SHORT_NS     = 495,
    parameter int         LONG_NS      = 660,
    parameter logic [7:0] A_RXDATA     = 8'h00,
    parameter logic [7:0] A_RXSTAT     = 8'h40,
    parameter logic [7:0] A_TXSTAT     = 8'h48,
    parameter logic [7:0] A_TEST       = 8'h64,
    parameter logic [7:0] A_RXINFO     = 8'h7C,
    parameter logic [7:0] A_TXINFO     = 8'h80,
    parameter logic [7:0] A_DROP       = 8'hA0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_dummy_mode,
    input  logic               h_valid,
    input  logic [ADDR_W-1:0]  h_addr,
    output logic               h_ready,
    output logic               d_valid,
    output logic [ADDR_W-1:0]  d_addr,
    output logic               d_dummy,
    input  logic               d_ready,
    output logic [STALL_W-1:0] stall_cnt
);

    logic [NCH-1:0] trig;
    logic [NCH-1:0] guard;
    logic [NCH-1:0] pending;
    logic           blocked;

    rhs_addr_classifier #(
        .ADDR_W   (ADDR_W),
        .A_RXDATA (A_RXDATA),
        .A_RXSTAT (A_RXSTAT),
        .A_TXSTAT (A_TXSTAT),
        .A_RXINFO (A_RXINFO),
        .A_TXINFO (A_TXINFO),
        .A_DROP   (A_DROP)
    ) u_cls (
        .addr  (h_addr),
        .trig  (trig),
        .guard (guard)
    );

    // One timer per channel; the dropped-frame channel uses the long interval
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int WNS = (ch == CH_DROP) ? LONG_NS : SHORT_NS;
        localparam int WC  = ceil_div(WNS * 1000, CLK_PS);
        localparam int DN  = ceil_div(WNS, BUS_CYCLE_NS);
        logic load_c;
        logic ack_c;
        assign load_c = h_valid && h_ready && trig[ch];
        assign ack_c  = d_valid && d_ready && d_dummy && guard[ch];
        rhs_hazard_timer #(
            .WAIT_CYC (WC),
            .DUMMY_N  (DN)
        ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_c),
            .dummy_ack (ack_c),
            .pending   (pending[ch])
        );
    end

    // Request is blocked when its guard channel is still pending
    assign blocked = h_valid && ((guard & pending) != '0);

    // Steer the downstream request: pass through, filler read, or nothing
    always_comb begin
        h_ready = d_ready && !blocked;
        d_valid = h_valid && (!blocked || cfg_dummy_mode);
        d_dummy = blocked && cfg_dummy_mode;
        d_addr  = blocked ? ADDR_W'(A_TEST) : h_addr;
    end

    rhs_stall_counter #(
        .STALL_W (STALL_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (blocked && d_ready),
        .count (stall_cnt)
    );

    AST_NO_EARLY_DEP: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_dummy) |-> ((guard & pending) == '0)); // R3
    AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_dummy) |-> (d_addr == h_addr)); // R2
    AST_DUMMY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        d_dummy |-> (cfg_dummy_mode && !h_ready && d_addr == ADDR_W'(A_TEST))); // R7
    AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        !d_ready |-> !h_ready); // R10
    AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && d_ready && !h_ready) |=> (stall_cnt != $past(stall_cnt))); // R9
    AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_valid || !d_ready) |=> $stable(stall_cnt)); // R9

endmodule

// File: tb/rd_hazard_spacer_tb.sv
// Scoreboard bench: the driver predicts each read's acceptance edge and queues it;
// the monitor pops and compares on every downstream acceptance.
module rd_hazard_spacer_tb;

    localparam logic [7:0] RXDATA = 8'h00, RXSTAT = 8'h40, TXSTAT = 8'h48;
    localparam logic [7:0] TEST = 8'h64, RXINFO = 8'h7C, TXINFO = 8'h80, DROP = 8'hA0;
    localparam logic [7:0] OTHER = 8'h10;
    // 495 ns and 660 ns at 8 ns per cycle, rounded up; filler reads at 165 ns each
    localparam int W_SHORT = (495 + 7) / 8;
    localparam int W_LONG  = (660 + 7) / 8;
    localparam int D_SHORT = (495 + 164) / 165;
    localparam int D_LONG  = (660 + 164) / 165;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dummy_mode = 1'b0;
    logic        h_valid = 1'b0;
    logic [7:0]  h_addr = '0;
    logic        h_ready;
    logic        d_valid;
    logic [7:0]  d_addr;
    logic        d_dummy;
    logic        d_ready = 1'b1;
    logic [15:0] stall_cnt;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int dummy_seen = 0;
    int exp_stall = 0;
    int last_edge [3] = '{-1000, -1000, -1000};
    logic [7:0] q_addr [$];
    int         q_edge [$];
    string      q_req [$];

    always #4 clk = ~clk;

    rd_hazard_spacer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_dummy_mode(cfg_dummy_mode),
        .h_valid(h_valid), .h_addr(h_addr), .h_ready(h_ready),
        .d_valid(d_valid), .d_addr(d_addr), .d_dummy(d_dummy),
        .d_ready(d_ready), .stall_cnt(stall_cnt)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int guard_of(input logic [7:0] a);
        if (a == RXINFO) return 0;
        if (a == TXINFO) return 1;
        if (a == DROP)   return 2;
        return -1;
    endfunction

    function automatic int trig_of(input logic [7:0] a);
        if (a == RXDATA || a == RXSTAT) return 0;
        if (a == TXSTAT) return 1;
        if (a == DROP)   return 2;
        return -1;
    endfunction

    // Monitor: samples shortly before each rising edge and scores accepted reads
    always begin
        @(negedge clk);
        #3;
        if (rst_n && d_valid && d_ready) begin
            if (d_dummy) begin
                dummy_seen++;
                check(d_addr == TEST, "R7", "filler address", d_addr, TEST);
            end else if (q_addr.size() == 0) begin
                check(1'b0, "R2", "unexpected downstream read", d_addr, 0);
            end else begin
                logic [7:0] ea;
                int ee;
                string rq;
                ea = q_addr.pop_front();
                ee = q_edge.pop_front();
                rq = q_req.pop_front();
                check(d_addr == ea, rq, "forwarded address", d_addr, ea);
                check(cyc == ee, rq, "acceptance edge", cyc, ee);
            end
        end
    end

    // Driver: predicts the acceptance edge, presents the read, waits for acceptance
    task automatic rd(input logic [7:0] a, input int hold, input string req);
        int p, e, g, t, blk, d0;
        @(negedge clk);
        p = cyc;
        e = p + hold;
        blk = 0;
        g = guard_of(a);
        if (g >= 0) begin
            int w, dn, he;
            w  = (g == 2) ? W_LONG : W_SHORT;
            dn = (g == 2) ? D_LONG : D_SHORT;
            he = last_edge[g] + w;
            if (cfg_dummy_mode && (p + dn < he)) he = p + dn;
            if (he > e) begin
                blk = he - e;
                e = he;
            end
        end
        q_addr.push_back(a);
        q_edge.push_back(e);
        q_req.push_back(req);
        exp_stall += blk;
        d0 = dummy_seen;
        h_valid = 1'b1;
        h_addr = a;
        if (hold > 0) begin
            d_ready = 1'b0;
            for (int i = 0; i < hold; i++) begin
                #1;
                check(h_ready == 1'b0, "R10", "h_ready under backpressure", h_ready, 0);
                @(negedge clk);
            end
            d_ready = 1'b1;
        end
        #1;
        while (!h_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        h_valid = 1'b0;
        t = trig_of(a);
        if (t >= 0) last_edge[t] = e;
        if (cfg_dummy_mode)
            check(dummy_seen - d0 == blk, "R7", "filler read count", dummy_seen - d0, blk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        check(stall_cnt == 0, "R1", "stall_cnt after reset", stall_cnt, 0);
        check(h_ready == 1'b1, "R1", "h_ready idle", h_ready, 1);
        check(d_valid == 1'b0, "R1", "d_valid idle", d_valid, 0);
        rd(RXINFO, 0, "R1");
        rd(DROP, 0, "R1");
        idle(100);
        // R3: receive data then receive info
        rd(RXDATA, 0, "R3");
        rd(RXINFO, 0, "R3");
        idle(100);
        // R2: unrelated reads pass and keep the receive hazard pending
        rd(RXSTAT, 0, "R2");
        rd(OTHER, 0, "R2");
        rd(TXINFO, 0, "R2");
        rd(RXINFO, 0, "R3");
        idle(100);
        // R4: transmit channel independent of receive channel
        rd(TXSTAT, 0, "R4");
        rd(RXINFO, 0, "R4");
        rd(TXINFO, 0, "R4");
        idle(100);
        // R5: dropped-frame counter spacing
        rd(DROP, 0, "R5");
        rd(DROP, 0, "R5");
        idle(100);
        // R6: second side-effect read restarts the interval
        rd(RXDATA, 0, "R6");
        idle(30);
        rd(RXSTAT, 0, "R6");
        rd(RXINFO, 0, "R6");
        idle(100);
        // R10: backpressure on an unrelated read
        rd(OTHER, 3, "R10");
        #1;
        check(stall_cnt == exp_stall, "R10", "stall_cnt after backpressure", stall_cnt, exp_stall);
        // R7: dummy-fill mode
        cfg_dummy_mode = 1'b1;
        idle(100);
        rd(RXDATA, 0, "R7");
        rd(RXINFO, 0, "R7");
        rd(DROP, 0, "R7");
        rd(DROP, 0, "R7");
        // R8: elapsed time satisfies the rule without filler reads
        rd(TXSTAT, 0, "R8");
        idle(70);
        rd(TXINFO, 0, "R8");
        idle(5);
        #1;
        // R9: total hazard stall cycles
        check(stall_cnt == exp_stall, "R9", "stall_cnt total", stall_cnt, exp_stall);
        check(q_addr.size() == 0, "R2", "reads left unscored", q_addr.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule